// File: doc/BRIEF.md
# Wide Register Write Collector

This block is the host-side bus interface unit for a bank of internal registers that are wider than the host bus. The host reaches the bank through a memory-mapped slave port. Each access is either one 32-bit dword or one 64-bit qword. Most registers are 128 bits wide and some table entries are 64 bits wide. A host cannot write such a register in one bus transfer, so the pieces are gathered in a collector. All bits reach the target register in one clock cycle, and only when the final piece arrives. Reads of a 128-bit register go through a shadow buffer. The first read of the register captures its whole value, and the later reads of its other parts return that snapshot.

Three narrow per-page registers bypass the collector: an event read pointer, a receive-descriptor doorbell and a transmit-descriptor doorbell. A single dword write to one of them takes effect at once, even in the middle of a wide write sequence. The register space repeats in pages. The register file itself is plain storage.

The collector is a three-state machine:
- `C_EMPTY`: nothing is gathered.
- `C_WIDE`: a partial 128-bit value is held.
- `C_SRAM`: a partial 64-bit table entry is held.

Its transitions are:
- *gather*: `C_EMPTY`→`C_WIDE` or `C_EMPTY`→`C_SRAM`, on a partial write.
- *extend*: the state is kept on a partial write to the same unit.
- *restart*: a partial write to another unit drops the old data and keeps or switches the state.
- *commit*: any state→`C_EMPTY`, on the final piece.

Narrow writes, whole 64-bit table writes, reads and unmapped accesses leave the machine alone.

Top module: `wide_write_collector`

## Requirements
- R1: A dword write to dword 0, 1 or 2 of a 128-bit register (address bits [3:2] = 0, 1, 2) only updates the collector. A later read of that register still returns its old value.
- R2: A dword write to dword 3 (bits [3:2] = 3) writes all 128 bits to the register in one cycle: the collected dwords 0 to 2 and the new dword 3.
- R3: A 64-bit write at offset 0 of a 128-bit register is collected as dwords 0 and 1. A 64-bit write at offset 8 commits, with the new data as bits [127:64].
- R4: Table entries are 64 bits wide at page-0 offset 0x1000 + 8·i. A dword write at entry offset 0 is collected. A dword write at offset 4 commits both dwords. A 64-bit write to an entry takes effect at once.
- R5: A read of dword 0 of a 128-bit register, or a 64-bit read at offset 0, copies the whole register into a shadow buffer. Reads of dwords 1 to 3, and a 64-bit read at offset 8, return shadow data even if the register has changed since.
- R6: Narrow registers sit at page offsets 0x200, 0x210 and 0x220, as 32 bits at offset 0 of each slot. A single dword write there takes effect immediately and reads back in the next read.
- R7: A narrow write between collected pieces neither changes nor commits the partly collected wide value.
- R8: The page number is address bit 13 and up, so a page is 0x2000 bytes. Each page has its own 128-bit and narrow registers.
- R9: 128-bit register i of a page is at offset 16·i. Registers at different indices are independent.
- R10: A partial write to a different register than the one being collected discards the old pieces. They are never committed.
- R11: A commit leaves the collector empty. Dwords that were not written since the last commit or restart are committed as zero.
- R12: After reset, every register reads zero, `req_ready` is high and `rsp_valid` is low. Read data is presented with `rsp_valid` exactly one cycle after the read is accepted. Unmapped, misaligned or out-of-page addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_qword | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data; dword accesses use bits [31:0] |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 64 | Read data, zero-extended for dword reads |

## Verification
Wide registers are written in four patterns. Each tells apart a different fault in the commit logic:
- Four ordered dwords separate commit-on-dword-3 from commit-on-every-write.
- Two qword halves check that the upper half alone triggers the commit.
- Sparse dwords show whether unwritten slots commit as zero or as stale data.
- Switching the address mid-sequence checks that the old partial is dropped.

A narrow doorbell write is placed between the pieces of a wide write to show that the bypass path leaves the collector alone. Reads of dword 0 are followed by a rewrite of the same register, so shadow-served reads can be told apart from live reads. Page-1 and table accesses check that the decode keeps the regions apart, and several unmapped addresses check the zero read.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
    typedef enum logic [1:0] {RG_NONE, RG_WIDE, RG_NARROW, RG_SRAM} region_e;
    typedef enum logic [1:0] {C_EMPTY, C_WIDE, C_SRAM} coll_state_e;

    localparam int PAGE_SHIFT      = 13;
    localparam int NARROW_LINE     = 32'h20;   // 16-byte line of first narrow slot
    localparam int NARROW_PER_PAGE = 3;
    localparam int SRAM_QLINE      = 32'h200;  // 8-byte line of first table entry
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
    import wrc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_PAGES = 2,
    parameter int NUM_WREGS = 4,
    parameter int NUM_SRAM  = 8,
    parameter int WFLAT_W   = 3,
    parameter int NFLAT_W   = 3,
    parameter int SIDX_W    = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               qword,
    output region_e            region,
    output logic [1:0]         dw,
    output logic [WFLAT_W-1:0] widx,
    output logic [NFLAT_W-1:0] nidx,
    output logic [SIDX_W-1:0]  sidx
);
    int pg, line, qline;

    assign dw = addr[3:2];

    always_comb begin
        pg     = int'(addr[ADDR_W-1:PAGE_SHIFT]);
        line   = int'(addr[PAGE_SHIFT-1:4]);
        qline  = int'(addr[PAGE_SHIFT-1:3]);
        region = RG_NONE;
        widx   = '0;
        nidx   = '0;
        sidx   = '0;
        if (addr[1:0] == 2'b00 && pg < NUM_PAGES) begin
            if (line < NUM_WREGS && !(qword && addr[2])) begin
                region = RG_WIDE;
                widx   = WFLAT_W'(pg * NUM_WREGS + line);
            end else if (line >= NARROW_LINE && line < NARROW_LINE + NARROW_PER_PAGE
                         && addr[3:2] == 2'b00) begin
                region = RG_NARROW;
                nidx   = NFLAT_W'(pg * NARROW_PER_PAGE + line - NARROW_LINE);
            end else if (pg == 0 && qline >= SRAM_QLINE && qline < SRAM_QLINE + NUM_SRAM
                         && !(qword && addr[2])) begin
                region = RG_SRAM;
                sidx   = SIDX_W'(qline - SRAM_QLINE);
            end
        end
    end
endmodule

// File: rtl/wrc_collector.sv
module wrc_collector
    import wrc_pkg::*;
#(
    parameter int TAG_W = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_fire,
    input  region_e       region,
    input  logic          qword,
    input  logic [1:0]    dw,
    input  logic [TAG_W-1:0] tag,
    input  logic [63:0]   wdata,
    output logic          commit_wide,
    output logic          commit_sram,
    output logic [127:0]  commit_data
);
    coll_state_e      state_q, state_d;
    logic [127:0]     buf_q, buf_d, base;
    logic [TAG_W-1:0] tag_q, tag_d, cur_tag;
    logic             hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= C_EMPTY;
            buf_q   <= '0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            buf_q   <= buf_d;
            tag_q   <= tag_d;
        end
    end

    // next state and outputs
    always_comb begin
        cur_tag = (region == RG_WIDE) ? {tag[TAG_W-1:1], 1'b0} : tag;
        hit = (tag_q == cur_tag) &&
              ((state_q == C_WIDE && region == RG_WIDE) ||
               (state_q == C_SRAM && region == RG_SRAM));
        base        = hit ? buf_q : '0;
        state_d     = state_q;
        buf_d       = buf_q;
        tag_d       = tag_q;
        commit_wide = 1'b0;
        commit_sram = 1'b0;
        commit_data = '0;
        if (wr_fire) begin
            unique case (region)
                RG_WIDE: begin
                    if (qword ? dw[1] : (dw == 2'd3)) begin          // commit
                        commit_wide = 1'b1;
                        commit_data = qword ? {wdata, base[63:0]}
                                            : {wdata[31:0], base[95:0]};
                        state_d = C_EMPTY;
                        buf_d   = '0;
                        tag_d   = '0;
                    end else begin                                   // gather / extend / restart
                        buf_d = base;
                        if (qword) buf_d[63:0] = wdata;
                        else       buf_d[{dw, 5'b0} +: 32] = wdata[31:0];
                        state_d = C_WIDE;
                        tag_d   = cur_tag;
                    end
                end
                RG_SRAM: begin
                    if (qword) begin                                 // direct, no collection
                        commit_sram = 1'b1;
                        commit_data = {64'b0, wdata};
                    end else if (dw[0]) begin                        // commit
                        commit_sram = 1'b1;
                        commit_data = {64'b0, wdata[31:0], base[31:0]};
                        state_d = C_EMPTY;
                        buf_d   = '0;
                        tag_d   = '0;
                    end else begin                                   // gather / restart
                        buf_d       = base;
                        buf_d[31:0] = wdata[31:0];
                        state_d     = C_SRAM;
                        tag_d       = cur_tag;
                    end
                end
                RG_NARROW, RG_NONE: begin
                end
            endcase
        end
    end

    assert_single_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_wide, commit_sram}));
    assert_commit_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_wide || (commit_sram && !qword)) |=> (state_q == C_EMPTY && buf_q == '0));
    assert_narrow_keeps_buf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && region == RG_NARROW) |=> ($stable(buf_q) && $stable(state_q)));
    assert_partial_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && region == RG_WIDE && !qword && dw != 2'd3) |=> (state_q == C_WIDE));
endmodule

// File: rtl/wrc_regfile.sv
module wrc_regfile
    import wrc_pkg::*;
#(
    parameter int NUM_W   = 8,
    parameter int NUM_N   = 6,
    parameter int NUM_S   = 8,
    parameter int WFLAT_W = 3,
    parameter int NFLAT_W = 3,
    parameter int SIDX_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_wide,
    input  logic               commit_sram,
    input  logic [127:0]       commit_data,
    input  logic               narrow_we,
    input  logic [31:0]        narrow_wdata,
    input  logic               rd_fire,
    input  region_e            region,
    input  logic               qword,
    input  logic [1:0]         dw,
    input  logic [WFLAT_W-1:0] widx,
    input  logic [NFLAT_W-1:0] nidx,
    input  logic [SIDX_W-1:0]  sidx,
    output logic               rsp_valid,
    output logic [63:0]        rsp_rdata
);
    logic [127:0] wide_q [NUM_W];
    logic [63:0]  sram_q [NUM_S];
    logic [31:0]  narrow_q [NUM_N];
    logic [127:0] shadow_q;
    logic         load_shadow;
    logic [63:0]  rd_d;

    always_comb begin
        load_shadow = rd_fire && region == RG_WIDE && (qword ? !dw[1] : dw == 2'd0);
        rd_d = '0;
        unique case (region)
            RG_WIDE:
                if (load_shadow) rd_d = qword ? wide_q[widx][63:0] : {32'b0, wide_q[widx][31:0]};
                else             rd_d = qword ? shadow_q[127:64] : {32'b0, shadow_q[{dw, 5'b0} +: 32]};
            RG_SRAM:
                if (qword) rd_d = sram_q[sidx];
                else       rd_d = {32'b0, dw[0] ? sram_q[sidx][63:32] : sram_q[sidx][31:0]};
            RG_NARROW: rd_d = {32'b0, narrow_q[nidx]};
            RG_NONE:   rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_W; i++) wide_q[i] <= '0;
            for (int i = 0; i < NUM_S; i++) sram_q[i] <= '0;
            for (int i = 0; i < NUM_N; i++) narrow_q[i] <= '0;
            shadow_q  <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (commit_wide) wide_q[widx] <= commit_data;
            if (commit_sram) sram_q[sidx] <= commit_data[63:0];
            if (narrow_we)   narrow_q[nidx] <= narrow_wdata;
            if (load_shadow) shadow_q <= wide_q[widx];
            rsp_valid <= rd_fire;
            rsp_rdata <= rd_fire ? rd_d : '0;
        end
    end

    assert_rsp_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> rsp_valid);
    assert_no_spurious_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> !rsp_valid);
    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && region == RG_NONE) |=> rsp_rdata == 64'b0);
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
    import wrc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_PAGES = 2,
    parameter int NUM_WREGS = 4,
    parameter int NUM_SRAM  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_qword,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata
);
    localparam int NUM_W   = NUM_PAGES * NUM_WREGS;
    localparam int NUM_N   = NUM_PAGES * NARROW_PER_PAGE;
    localparam int WFLAT_W = $clog2(NUM_W);
    localparam int NFLAT_W = $clog2(NUM_N);
    localparam int SIDX_W  = $clog2(NUM_SRAM);
    localparam int TAG_W   = ADDR_W - 3;

    region_e            region;
    logic [1:0]         dw;
    logic [WFLAT_W-1:0] widx;
    logic [NFLAT_W-1:0] nidx;
    logic [SIDX_W-1:0]  sidx;
    logic               wr_fire, rd_fire;
    logic               commit_wide, commit_sram;
    logic [127:0]       commit_data;

    assign req_ready = 1'b1;
    assign wr_fire   = req_valid && req_ready && req_write;
    assign rd_fire   = req_valid && req_ready && !req_write;

    wrc_decode #(
        .ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES), .NUM_WREGS(NUM_WREGS), .NUM_SRAM(NUM_SRAM),
        .WFLAT_W(WFLAT_W), .NFLAT_W(NFLAT_W), .SIDX_W(SIDX_W)
    ) u_decode (
        .addr(req_addr), .qword(req_qword), .region(region), .dw(dw),
        .widx(widx), .nidx(nidx), .sidx(sidx)
    );

    wrc_collector #(.TAG_W(TAG_W)) u_collector (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .region(region), .qword(req_qword),
        .dw(dw), .tag(req_addr[ADDR_W-1:3]), .wdata(req_wdata),
        .commit_wide(commit_wide), .commit_sram(commit_sram), .commit_data(commit_data)
    );

    wrc_regfile #(
        .NUM_W(NUM_W), .NUM_N(NUM_N), .NUM_S(NUM_SRAM),
        .WFLAT_W(WFLAT_W), .NFLAT_W(NFLAT_W), .SIDX_W(SIDX_W)
    ) u_regfile (
        .clk(clk), .rst_n(rst_n), .commit_wide(commit_wide), .commit_sram(commit_sram),
        .commit_data(commit_data), .narrow_we(wr_fire && region == RG_NARROW),
        .narrow_wdata(req_wdata[31:0]), .rd_fire(rd_fire), .region(region),
        .qword(req_qword), .dw(dw), .widx(widx), .nidx(nidx), .sidx(sidx),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );
endmodule

// File: tb/tb_wide_write_collector.sv
module tb_wide_write_collector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_qword = 1'b0;
    logic [15:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [63:0] rsp_rdata;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;
    logic [63:0] exp_q[$];
    string       lab_q[$];

    always #4 clk = ~clk;   // 125 MHz

    wide_write_collector dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_qword(req_qword), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [15:0] wa(int pg, int i, int d);
        return 16'(pg * 'h2000 + i * 16 + d * 4);
    endfunction
    function automatic logic [15:0] na(int pg, int k);
        return 16'(pg * 'h2000 + 'h200 + k * 16);
    endfunction
    function automatic logic [15:0] sa(int i, int hi);
        return 16'('h1000 + i * 8 + hi * 4);
    endfunction

    task automatic drive(input logic w, input logic q, input logic [15:0] a, input logic [63:0] d);
        req_valid = 1'b1; req_write = w; req_qword = q; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask
    task automatic wr32(input logic [15:0] a, input logic [31:0] d);
        drive(1'b1, 1'b0, a, {32'h0, d});
    endtask
    task automatic wr64(input logic [15:0] a, input logic [63:0] d);
        drive(1'b1, 1'b1, a, d);
    endtask
    task automatic rd32(input logic [15:0] a, input logic [31:0] e, input string lab);
        exp_q.push_back({32'h0, e}); lab_q.push_back(lab);
        drive(1'b0, 1'b0, a, '0);
    endtask
    task automatic rd64(input logic [15:0] a, input logic [63:0] e, input string lab);
        exp_q.push_back(e); lab_q.push_back(lab);
        drive(1'b0, 1'b1, a, '0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid && !finished) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R12 unexpected response: actual %h expected none", rsp_rdata);
            end else begin
                logic [63:0] e;
                string l;
                e = exp_q.pop_front();
                l = lab_q.pop_front();
                if (rsp_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", l, rsp_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        n_vec++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R12 reset: actual ready=%b valid=%b expected ready=1 valid=0", req_ready, rsp_valid);
        end
        rd32(wa(0,0,0), 32'h0, "R12 reset zero");

        // R1 / R2 ordered dwords
        wr32(wa(0,1,0), 32'hA0A0_0000);
        wr32(wa(0,1,1), 32'hA1A1_1111);
        wr32(wa(0,1,2), 32'hA2A2_2222);
        rd32(wa(0,1,0), 32'h0, "R1 not yet committed");
        wr32(wa(0,1,3), 32'hA3A3_3333);
        rd32(wa(0,1,0), 32'hA0A0_0000, "R2 dw0");
        rd32(wa(0,1,1), 32'hA1A1_1111, "R2 dw1");
        rd32(wa(0,1,2), 32'hA2A2_2222, "R2 dw2");
        rd32(wa(0,1,3), 32'hA3A3_3333, "R2 dw3");

        // R3 qword halves
        wr64(wa(0,2,0), 64'h1111_2222_3333_4444);
        rd64(wa(0,2,0), 64'h0, "R3 lower half held");
        wr64(wa(0,2,2), 64'h5555_6666_7777_8888);
        rd64(wa(0,2,0), 64'h1111_2222_3333_4444, "R3 lower");
        rd64(wa(0,2,2), 64'h5555_6666_7777_8888, "R3 upper");

        // R5 shadow
        rd32(wa(0,1,0), 32'hA0A0_0000, "R5 load shadow");
        wr32(wa(0,1,0), 32'hB0B0_0000);
        wr32(wa(0,1,1), 32'hB1B1_1111);
        wr32(wa(0,1,2), 32'hB2B2_2222);
        wr32(wa(0,1,3), 32'hB3B3_3333);
        rd32(wa(0,1,2), 32'hA2A2_2222, "R5 shadow not live");
        rd32(wa(0,1,0), 32'hB0B0_0000, "R5 reload");
        rd32(wa(0,1,3), 32'hB3B3_3333, "R5 new shadow");

        // R6 narrow registers
        wr32(na(0,0), 32'hE7E7_0001);
        rd32(na(0,0), 32'hE7E7_0001, "R6 event ptr");
        wr32(na(0,2), 32'h7C7C_0002);
        rd32(na(0,2), 32'h7C7C_0002, "R6 tx doorbell");
        wr32(na(1,1), 32'h5A5A_0005);
        rd32(na(1,1), 32'h5A5A_0005, "R6 page1 rx doorbell");

        // R7 narrow write mid-collection
        wr32(wa(0,3,0), 32'hC0C0_0000);
        wr32(wa(0,3,1), 32'hC1C1_1111);
        wr32(na(0,1), 32'hD0D0_0001);
        rd32(wa(0,3,0), 32'h0, "R7 no commit from narrow");
        wr32(wa(0,3,2), 32'hC2C2_2222);
        wr32(wa(0,3,3), 32'hC3C3_3333);
        rd32(wa(0,3,0), 32'hC0C0_0000, "R7 dw0 intact");
        rd32(wa(0,3,1), 32'hC1C1_1111, "R7 dw1 intact");
        rd32(wa(0,3,3), 32'hC3C3_3333, "R7 dw3");
        rd32(na(0,1), 32'hD0D0_0001, "R7 narrow took effect");

        // R8 paging
        wr32(wa(1,1,0), 32'hD0D0_1000);
        wr32(wa(1,1,1), 32'hD1D1_1001);
        wr32(wa(1,1,2), 32'hD2D2_1002);
        wr32(wa(1,1,3), 32'hD3D3_1003);
        rd32(wa(1,1,0), 32'hD0D0_1000, "R8 page1 dw0");
        rd32(wa(1,1,3), 32'hD3D3_1003, "R8 page1 dw3");
        rd32(wa(0,1,0), 32'hB0B0_0000, "R8 page0 untouched");

        // R9 index stride
        wr64(wa(0,0,0), 64'hE1E1E1E1_E0E0E0E0);
        wr64(wa(0,0,2), 64'hE3E3E3E3_E2E2E2E2);
        rd32(wa(0,0,0), 32'hE0E0E0E0, "R9 reg0 dw0");
        rd32(wa(0,0,2), 32'hE2E2E2E2, "R9 reg0 dw2");
        rd32(wa(0,2,0), 32'h3333_4444, "R9 reg2 independent");

        // R10 restart on address change
        wr32(wa(0,0,0), 32'hF0F0_0000);
        wr32(wa(0,0,1), 32'hF1F1_1111);
        wr32(wa(0,2,1), 32'h6161_1111);
        wr32(wa(0,2,3), 32'h6363_3333);
        rd32(wa(0,2,0), 32'h0, "R10 dropped dw0");
        rd32(wa(0,2,1), 32'h6161_1111, "R10 new dw1");
        rd32(wa(0,2,2), 32'h0, "R10 dropped dw2");
        rd32(wa(0,2,3), 32'h6363_3333, "R10 new dw3");
        rd32(wa(0,0,0), 32'hE0E0E0E0, "R10 old target unchanged");

        // R11 empty after commit, unwritten dwords zero
        wr32(wa(0,0,3), 32'h4343_3333);
        rd32(wa(0,0,0), 32'h0, "R11 dw0 zero");
        rd32(wa(0,0,1), 32'h0, "R11 dw1 zero");
        rd32(wa(0,0,3), 32'h4343_3333, "R11 dw3");
        wr32(wa(0,3,1), 32'hB1B1_0101);
        wr32(wa(0,3,3), 32'hB3B3_0303);
        rd32(wa(0,3,0), 32'h0, "R11 sparse dw0");
        rd32(wa(0,3,1), 32'hB1B1_0101, "R11 sparse dw1");
        rd32(wa(0,3,2), 32'h0, "R11 sparse dw2");

        // R4 table entries
        wr32(sa(2,0), 32'h5050_0000);
        rd64(sa(2,0), 64'h0, "R4 low held");
        wr32(sa(2,1), 32'h5151_1111);
        rd64(sa(2,0), 64'h5151_1111_5050_0000, "R4 commit");
        rd32(sa(2,1), 32'h5151_1111, "R4 dword hi");
        wr64(sa(5,0), 64'h0123_4567_89AB_CDEF);
        rd64(sa(5,0), 64'h0123_4567_89AB_CDEF, "R4 direct qword");

        // R12 unmapped
        rd32(16'h0800, 32'h0, "R12 gap");
        rd32(16'h4000, 32'h0, "R12 page out of range");
        rd32(16'h0204, 32'h0, "R12 narrow slot dw1");
        rd64(16'h3010, 64'h0, "R12 table on page1");
        rd32(16'h0001, 32'h0, "R12 misaligned");

        repeat (4) @(negedge clk);
        n_vec++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R12 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule